// File: doc/BRIEF.md
# Probabilistic Counter Rescaling Engine

This block widens the range of an array of approximate flow counters. Each flow keeps a short index into a shared, ascending table of estimate values. When the increment path writes an index at or above a threshold, the engine starts an upscale. From then on a coarser table, built for a larger relative error, is in use. The engine walks the whole pointer memory in address order and rewrites each index so that it points into the coarser table.

An old estimate v is looked up in the old table. The engine then finds the two neighbouring entries of the new table, lo ≤ v < hi, and moves the flow to the upper one with probability (v − lo)/(hi − lo). Otherwise the flow goes to the lower one, so the expected estimate does not change. An estimate that equals a new entry keeps that entry. The caller supplies both tables precomputed, together with a fresh random byte each cycle. While the scan runs, `busy` tells the increment path to hold off. A one-cycle `done` pulse marks the end of the scan, and `tbl_sel` flips at the same moment to select the new table.

Top module: `rescale_engine`

## Requirements
- R1: After reset `busy`, `done`, `ptr_wr_en` and `tbl_sel` are all 0.
- R2: A scan starts only when `inc_valid` is 1 with `inc_ptr` ≥ THRESH while the engine is idle. An index below THRESH causes no write and no change of `tbl_sel`.
- R3: A scan writes every flow address 0..N−1 exactly once, in ascending order, one per cycle. The first write is enabled in the second cycle after the trigger edge.
- R4: An old estimate equal to a new table entry maps to that entry's index, whatever the random value.
- R5: The written index is always j or j+1, where new[j] ≤ v < new[j+1]. Table entry k occupies bits [k*W +: W] of its table port.
- R6: `rnd` is read as an unsigned fraction rnd/2^RW. The flow moves up exactly when rnd·(hi−lo) < (v−lo)·2^RW.
- R7: Over many flows with varying `rnd`, the mean converted estimate matches the old estimate.
- R8: `done` is high for exactly one cycle, the cycle after the last write. `tbl_sel` inverts on that same edge.
- R9: `busy` is high from the cycle after the trigger edge through the last write. A trigger that arrives while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inc_valid | input | 1 | The increment path is writing an index |
| inc_ptr | input | IW | Index being written by the increment path |
| old_table | input | L*W | Current estimate table, entry k at [k*W +: W] |
| new_table | input | L*W | Coarser replacement table, ascending |
| rnd | input | RW | Random byte, used in the write cycle |
| ptr_rd_addr | output | AW | Pointer memory read address (data returns one cycle later) |
| ptr_rd_data | input | IW | Pointer memory read data |
| ptr_wr_en | output | 1 | Pointer memory write enable |
| ptr_wr_addr | output | AW | Pointer memory write address |
| ptr_wr_data | output | IW | Converted index |
| busy | output | 1 | Scan in progress; increments must wait |
| done | output | 1 | One-cycle end-of-scan pulse |
| tbl_sel | output | 1 | Selects the active table, inverts at each completed scan |

## Verification
If the trigger is sampled on edge t0, `busy` is visible in the cycle after t0. The write for flow k is enabled in the cycle after edge t0+1+k, and `done` is visible in the cycle after edge t0+N+1, which is the (N+2)th falling edge. The bench samples on falling edges only and counts those edges from the trigger to `done`. Each converted index is compared against a bench copy of the memory after `done`. `rnd` is changed only on falling edges, so the value used in each write cycle is the one the bench chose.

// File: rtl/rescale_pkg.sv
package rescale_pkg;
  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_SCAN = 1'b1
  } scan_state_t;
endpackage

// File: rtl/rescale_search.sv
// Finds the bracketing pair of new-table entries around an estimate.
module rescale_search #(
  parameter int L  = 8,
  parameter int W  = 16,
  parameter int IW = $clog2(L)
) (
  input  logic [L*W-1:0] tbl,
  input  logic [W-1:0]   v,
  output logic [IW-1:0]  lo_idx,
  output logic [W-1:0]   lo_val,
  output logic [W-1:0]   hi_val,
  output logic           at_top
);
  localparam logic [IW-1:0] TOP = IW'(L - 1);

  function automatic logic [W-1:0] entry(input logic [L*W-1:0] t, input logic [IW-1:0] k);
    return t[k*W +: W];
  endfunction

  // Linear monotone search: last entry not above v.
  always_comb begin
    lo_idx = '0;
    for (int k = 1; k < L; k++) begin
      if (entry(tbl, IW'(k)) <= v) lo_idx = IW'(k);
    end
  end

  logic [IW-1:0] hi_idx;
  assign at_top = (lo_idx == TOP);
  assign hi_idx = at_top ? lo_idx : lo_idx + 1'b1;
  assign lo_val = entry(tbl, lo_idx);
  assign hi_val = entry(tbl, hi_idx);
endmodule

// File: rtl/rescale_decide.sv
// Chooses the upper neighbour with probability (v-lo)/(hi-lo).
module rescale_decide #(
  parameter int W  = 16,
  parameter int RW = 8
) (
  input  logic [W-1:0]  v,
  input  logic [W-1:0]  lo_val,
  input  logic [W-1:0]  hi_val,
  input  logic          at_top,
  input  logic [RW-1:0] rnd,
  output logic          go_up
);
  localparam int PW = W + RW;

  // rnd/2^RW < diff/span  <=>  rnd*span < diff*2^RW ; no divider needed
  function automatic logic up_choice(input logic [W-1:0] val, input logic [W-1:0] lo,
                                     input logic [W-1:0] hi, input logic [RW-1:0] r);
    logic [W-1:0]  span;
    logic [W-1:0]  diff;
    logic [PW-1:0] lhs;
    logic [PW-1:0] rhs;
    span = hi - lo;
    diff = val - lo;
    lhs  = PW'(r) * PW'(span);
    rhs  = {diff, {RW{1'b0}}};
    return lhs < rhs;
  endfunction

  assign go_up = !at_top && up_choice(v, lo_val, hi_val, rnd);
endmodule

// File: rtl/rescale_ctrl.sv
// Scan sequencer: read address counter, one-stage read pipeline, done pulse.
module rescale_ctrl
  import rescale_pkg::*;
#(
  parameter int N      = 16,
  parameter int L      = 8,
  parameter int THRESH = 6,
  parameter int IW     = $clog2(L),
  parameter int AW     = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc_valid,
  input  logic [IW-1:0] inc_ptr,
  output logic [AW-1:0] rd_addr,
  output logic          s1_valid,
  output logic [AW-1:0] s1_addr,
  output logic          busy,
  output logic          done,
  output logic          tbl_sel
);
  localparam logic [AW-1:0] LAST = AW'(N - 1);

  scan_state_t   state;
  logic [AW-1:0] rd_idx;
  logic          start_evt;
  logic          last_rd;
  logic          last_wr;

  assign busy      = (state == ST_SCAN) || s1_valid;
  assign start_evt = !busy && inc_valid && (inc_ptr >= IW'(THRESH));
  assign last_rd   = (state == ST_SCAN) && (rd_idx == LAST);
  assign last_wr   = s1_valid && (s1_addr == LAST);
  assign rd_addr   = rd_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      rd_idx   <= '0;
      s1_valid <= 1'b0;
      s1_addr  <= '0;
      done     <= 1'b0;
      tbl_sel  <= 1'b0;
    end else begin
      s1_valid <= (state == ST_SCAN);
      s1_addr  <= rd_idx;
      done     <= last_wr;
      if (last_wr) tbl_sel <= ~tbl_sel;
      case (state)
        ST_IDLE: begin
          rd_idx <= '0;
          if (start_evt) state <= ST_SCAN;
        end
        ST_SCAN: begin
          rd_idx <= rd_idx + 1'b1;
          if (last_rd) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  p_trigger_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && inc_valid && inc_ptr >= IW'(THRESH)) |=> busy);

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_sel_flip_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (tbl_sel != $past(tbl_sel)));
endmodule

// File: rtl/rescale_engine.sv
module rescale_engine #(
  parameter int N      = 16,
  parameter int L      = 8,
  parameter int W      = 16,
  parameter int RW     = 8,
  parameter int THRESH = 6,
  parameter int IW     = $clog2(L),
  parameter int AW     = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc_valid,
  input  logic [IW-1:0] inc_ptr,
  input  logic [L*W-1:0] old_table,
  input  logic [L*W-1:0] new_table,
  input  logic [RW-1:0] rnd,
  output logic [AW-1:0] ptr_rd_addr,
  input  logic [IW-1:0] ptr_rd_data,
  output logic          ptr_wr_en,
  output logic [AW-1:0] ptr_wr_addr,
  output logic [IW-1:0] ptr_wr_data,
  output logic          busy,
  output logic          done,
  output logic          tbl_sel
);
  localparam logic [IW-1:0] TOP = IW'(L - 1);

  function automatic logic [W-1:0] entry(input logic [L*W-1:0] t, input logic [IW-1:0] k);
    return t[k*W +: W];
  endfunction

  logic          s1_valid;
  logic [AW-1:0] s1_addr;
  logic [W-1:0]  old_val;
  logic [IW-1:0] lo_idx;
  logic [W-1:0]  lo_val;
  logic [W-1:0]  hi_val;
  logic          at_top;
  logic          go_up;

  rescale_ctrl #(.N(N), .L(L), .THRESH(THRESH), .IW(IW), .AW(AW)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .inc_valid(inc_valid), .inc_ptr(inc_ptr),
    .rd_addr(ptr_rd_addr), .s1_valid(s1_valid), .s1_addr(s1_addr),
    .busy(busy), .done(done), .tbl_sel(tbl_sel)
  );

  assign old_val = entry(old_table, ptr_rd_data);

  rescale_search #(.L(L), .W(W), .IW(IW)) search_i (
    .tbl(new_table), .v(old_val), .lo_idx(lo_idx),
    .lo_val(lo_val), .hi_val(hi_val), .at_top(at_top)
  );

  rescale_decide #(.W(W), .RW(RW)) decide_i (
    .v(old_val), .lo_val(lo_val), .hi_val(hi_val),
    .at_top(at_top), .rnd(rnd), .go_up(go_up)
  );

  assign ptr_wr_en   = s1_valid;
  assign ptr_wr_addr = s1_addr;
  assign ptr_wr_data = lo_idx + IW'(go_up);

  // R4 is covered too: an exact match can only satisfy the first clause.
  p_bracket_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_wr_en |->
      ((entry(new_table, ptr_wr_data) <= old_val &&
        (ptr_wr_data == TOP || entry(new_table, ptr_wr_data + 1'b1) > old_val)) ||
       (entry(new_table, ptr_wr_data) > old_val && ptr_wr_data != '0 &&
        entry(new_table, ptr_wr_data - 1'b1) < old_val)));

  p_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_wr_en && $past(ptr_wr_en)) |-> (ptr_wr_addr == $past(ptr_wr_addr) + 1'b1));

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_wr_en |-> busy);
endmodule

// File: tb/rescale_engine_tb_top.sv
`timescale 1ns/1ps
module rescale_engine_tb_top;
  localparam int N = 16, L = 8, W = 16, RW = 8, THRESH = 6, IW = 3, AW = 4;
  localparam int NV = 5;
  // old table: 0 1 3 5 11 54 132 211 ; new table: 0 2 5 24 93 156 314 517
  localparam logic [W-1:0] OLD_V [L] = '{0, 1, 3, 5, 11, 54, 132, 211};
  localparam logic [W-1:0] NEW_V [L] = '{0, 2, 5, 24, 93, 156, 314, 517};
  localparam logic [RW-1:0] VEC_RND [NV] = '{8'd0, 8'd255, 8'd128, 8'd100, 8'd127};
  localparam logic [IW-1:0] VEC_MAP [NV][L] = '{
    '{0, 1, 2, 2, 3, 4, 5, 6},
    '{0, 0, 1, 2, 2, 3, 4, 5},
    '{0, 0, 1, 2, 2, 3, 5, 5},
    '{0, 1, 1, 2, 2, 4, 5, 5},
    '{0, 1, 1, 2, 2, 3, 5, 5}
  };

  logic clk = 0, rst_n = 0, inc_valid = 0;
  logic [IW-1:0] inc_ptr = '0;
  logic [L*W-1:0] old_table, new_table;
  logic [RW-1:0] rnd = '0, fixed_rnd = '0;
  logic rng_mode = 0;
  logic [31:0] xs = 32'h1234_5678;
  logic [AW-1:0] ptr_rd_addr, ptr_wr_addr;
  logic [IW-1:0] ptr_rd_data = '0, ptr_wr_data;
  logic ptr_wr_en, busy, done, tbl_sel;
  logic [IW-1:0] mem [N];
  logic load_en = 0, load_mod = 0;
  logic [IW-1:0] load_val = '0;
  int wr_count = 0, checks = 0, failures = 0;
  logic exp_sel = 0;

  always #10 clk = ~clk;

  for (genvar k = 0; k < L; k++) begin : g_tbl
    assign old_table[k*W +: W] = OLD_V[k];
    assign new_table[k*W +: W] = NEW_V[k];
  end

  rescale_engine #(.N(N), .L(L), .W(W), .RW(RW), .THRESH(THRESH)) dut_i (
    .clk(clk), .rst_n(rst_n), .inc_valid(inc_valid), .inc_ptr(inc_ptr),
    .old_table(old_table), .new_table(new_table), .rnd(rnd),
    .ptr_rd_addr(ptr_rd_addr), .ptr_rd_data(ptr_rd_data), .ptr_wr_en(ptr_wr_en),
    .ptr_wr_addr(ptr_wr_addr), .ptr_wr_data(ptr_wr_data),
    .busy(busy), .done(done), .tbl_sel(tbl_sel)
  );

  always @(posedge clk) begin
    ptr_rd_data <= mem[ptr_rd_addr];
    if (load_en) begin
      for (int i = 0; i < N; i++) mem[i] <= load_mod ? IW'(i % L) : load_val;
    end else if (ptr_wr_en) begin
      mem[ptr_wr_addr] <= ptr_wr_data;
      wr_count <= wr_count + 1;
    end
  end

  always @(negedge clk) begin
    xs  <= xs ^ (xs << 13) ^ ((xs ^ (xs << 13)) >> 17) ^
           ((xs ^ (xs << 13) ^ ((xs ^ (xs << 13)) >> 17)) << 5);
    rnd <= rng_mode ? xs[31:24] : fixed_rnd;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic load(input bit by_index, input logic [IW-1:0] v);
    @(negedge clk);
    load_mod = by_index; load_val = v; load_en = 1;
    @(negedge clk);
    load_en = 0;
  endtask

  // trigger on one edge, count falling edges until done
  task automatic run_scan(input logic [IW-1:0] trig, output int cyc);
    @(negedge clk);
    inc_valid = 1; inc_ptr = trig;
    @(negedge clk);
    inc_valid = 0;
    cyc = 1;
    while (!done && cyc < 200) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  initial begin
    int cyc, w0;
    longint sum;
    int bad;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!busy && !done && !ptr_wr_en && !tbl_sel, "R1", {busy, done, ptr_wr_en, tbl_sel}, 0);
    rst_n = 1;
    load(1, '0);
    rng_mode = 0;

    // vector table: fixed rnd, flow i holds old index i%L
    for (int v = 0; v < NV; v++) begin
      fixed_rnd = VEC_RND[v];
      load(1, '0);
      w0 = wr_count;
      run_scan(IW'(7), cyc);
      exp_sel = ~exp_sel;
      check(cyc == N + 2, "R3/R8 done timing", cyc, N + 2);
      check(wr_count - w0 == N, "R3 write count", wr_count - w0, N);
      check(tbl_sel == exp_sel, "R8 tbl_sel", tbl_sel, exp_sel);
      @(negedge clk);
      check(!done, "R8 done one cycle", done, 0);
      for (int i = 0; i < N; i++)
        check(mem[i] == VEC_MAP[v][i % L], (i % L == 3 || i % L == 0) ? "R4 exact" : "R6 decision",
              mem[i], VEC_MAP[v][i % L]);
    end

    // R2: below threshold nothing happens
    load(1, '0);
    w0 = wr_count;
    @(negedge clk); inc_valid = 1; inc_ptr = IW'(THRESH - 1);
    @(negedge clk); inc_valid = 0;
    repeat (4) @(negedge clk);
    check(!busy && wr_count == w0 && tbl_sel == exp_sel, "R2 below threshold", wr_count - w0, 0);
    check(mem[5] == 3'd5, "R2 memory untouched", mem[5], 5);

    // R9: busy timing and retrigger ignored
    fixed_rnd = 8'd0;
    load(1, '0);
    w0 = wr_count;
    @(negedge clk); inc_valid = 1; inc_ptr = IW'(THRESH);
    @(negedge clk); inc_valid = 0;
    check(busy, "R9 busy after trigger", busy, 1);
    repeat (5) @(negedge clk);
    inc_valid = 1; inc_ptr = IW'(7);
    @(negedge clk); inc_valid = 0;
    cyc = 7;
    while (!done && cyc < 200) begin
      check(busy, "R9 busy during scan", busy, 1);
      @(negedge clk); cyc++;
    end
    exp_sel = ~exp_sel;
    check(cyc == N + 2 && !busy, "R9 end of busy", cyc, N + 2);
    repeat (25) @(negedge clk);
    check(wr_count - w0 == N && tbl_sel == exp_sel, "R9 retrigger ignored", wr_count - w0, N);

    // R5/R7: random conversion of old estimate 54 (index 5), many trials
    rng_mode = 1;
    sum = 0; bad = 0;
    for (int r = 0; r < 64; r++) begin
      load(0, 3'd5);
      run_scan(IW'(7), cyc);
      exp_sel = ~exp_sel;
      @(negedge clk);
      for (int i = 0; i < N; i++) begin
        if (mem[i] != 3'd3 && mem[i] != 3'd4) bad++;
        sum += NEW_V[mem[i]];
      end
    end
    check(bad == 0, "R5 bracket", bad, 0);
    check(sum > 54 * 1024 - 5 * 1024 && sum < 54 * 1024 + 5 * 1024, "R7 mean",
          int'(sum / 1024), 54);
    check(tbl_sel == exp_sel, "R8 tbl_sel after trials", tbl_sel, exp_sel);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(20 * 150000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule